// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging by its 48-bit destination address alone. A frame parser upstream extracts the address and offers it on a valid/ready lookup port. The block compares it against a small bank of exact-match address entries and against a multicast hash table, then combines the two results under a five-bit mode word. One cycle after a lookup is taken, a registered verdict appears on a valid/ready result port. The verdict carries accept, exact-match hit, the index of the matching entry and a flag that says control frames may pass.

Configuration uses a flat word-addressed register port with a combinational read path. The hash bin of an address is taken from the standard Ethernet CRC-32 of its six bytes. Software fills the hash words with bits for the bins it wants, and fills or clears the exact-match entries. Bin count and entry count are parameters.

Back-pressure rules: a lookup transfers on a clock edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the result slot is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, every result field holds its value. The verdict uses the configuration registers as they stand in the cycle the lookup transfers.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid` is low, `lk_ready` is high and every configuration register reads zero.
- R2: Register map (word addresses). Word 0 holds the mode in bits 4:0. Entry i has its low word at 16+2i and its high word at 17+2i. Hash word k is at 32+k. In a high word, bit 31 is the enable bit and bits 15:0 hold address bytes 4 and 5; every other bit reads zero. Unmapped addresses read zero and ignore writes.
- R3: An entry matches when its enable bit is set and the 48-bit address equals {high[15:0], low[31:0]}. Byte 0 of the address is `lk_da[7:0]` and sits in low bits 7:0. An entry with its enable bit clear never matches. `res_perfect_hit` reports any match, and `res_index` gives the lowest matching entry, or 0 when there is none.
- R4: Hash bin: run the reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over `lk_da` from bit 0 upward, then complement the result. Bit-reverse it and keep the top log2(HASH_BINS) bits. Bin n is hash word n>>5, bit n&31. A set bit is a hash hit.
- R5: A group address (`lk_da[0]`=1) with mode bit 2 clear is accepted only by an exact match. With mode bit 2 set, it is accepted by a hash hit.
- R6: An individual address (`lk_da[0]`=0) with mode bit 3 clear is accepted only by an exact match. With mode bit 3 set, it is accepted by a hash hit.
- R7: Mode bit 4 (hash-or-exact) lets an exact match also accept an address whose class is under hash filtering per R5/R6. With bit 4 clear, such an address needs a hash hit.
- R8: Mode bit 1 accepts every group address.
- R9: Mode bit 0 (promiscuous) accepts every address and drives `res_pass_ctrl` high. Otherwise `res_pass_ctrl` is low.
- R10: The broadcast address (all ones) is always accepted.
- R11: A transferred lookup gives `res_valid` on the next edge. `res_valid` and all result fields hold while `res_ready` is low, and `lk_ready` is low in that state. The result slot empties on the edge after it is drained if no new lookup transfers on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumer ready |
| res_accept | output | 1 | Frame accepted |
| res_perfect_hit | output | 1 | Some enabled entry matched exactly |
| res_index | output | IDXW | Lowest matching entry index |
| res_pass_ctrl | output | 1 | Control frames may pass (promiscuous) |

## Verification
The bench sweeps all 32 mode words against addresses chosen to sit on every decision edge. These include enabled and disabled entries, group and individual addresses that hit or miss the hash, and broadcast. A design that mixed up the class gating of R5 to R7 would accept or drop whole classes in the wrong modes. A design that ignored the enable bit would report hits on a disabled entry. The bench also walks a single set bit across all 64 bins and predicts each verdict from a forward-form CRC of its own. A bit-order or reflection slip in the bin arithmetic would therefore land hits in the wrong bin. Further cases cover two entries holding the same address, where a wrong priority encoder reports the higher index. Under held back-pressure, a slot that was not frozen would let a queued broadcast overwrite the pending verdict.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  // Mode word, bit 0 at the bottom.
  typedef struct packed {
    logic hash_or_exact;  // bit 4
    logic hash_ucast;     // bit 3
    logic hash_mcast;     // bit 2
    logic pass_mcast;     // bit 1
    logic promisc;        // bit 0
  } filt_mode_t;

  localparam int MODE_W    = 5;
  localparam int ADDR_MODE = 0;
  localparam int ENT_BASE  = 16;
  localparam int HASH_BASE = 32;
  localparam int EN_BIT    = 31;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/afilt_regs.sv
module afilt_regs
  import afilt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int HASH_WORDS  = 2,
  parameter int CFG_AW      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output filt_mode_t        mode_o,
  output logic [31:0]       ent_lo_o [NUM_ENTRIES],
  output logic [31:0]       ent_hi_o [NUM_ENTRIES],
  output logic [31:0]       hash_o   [HASH_WORDS]
);

  localparam logic [31:0] HI_MASK = 32'h8000_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_o <= '0;
    else if (we_i && addr_i == CFG_AW'(ADDR_MODE))
      mode_o <= filt_mode_t'(wdata_i[MODE_W-1:0]);
  end

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_lo_o[gi] <= '0;
        ent_hi_o[gi] <= '0;
      end else if (we_i) begin
        if (addr_i == CFG_AW'(ENT_BASE + 2*gi))
          ent_lo_o[gi] <= wdata_i;
        if (addr_i == CFG_AW'(ENT_BASE + 2*gi + 1))
          ent_hi_o[gi] <= wdata_i & HI_MASK;
      end
    end
  end

  for (genvar gk = 0; gk < HASH_WORDS; gk++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rst_n)
        hash_o[gk] <= '0;
      else if (we_i && addr_i == CFG_AW'(HASH_BASE + gk))
        hash_o[gk] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_AW'(ADDR_MODE))
      rdata_o = 32'(mode_o);
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (addr_i == CFG_AW'(ENT_BASE + 2*i))     rdata_o = ent_lo_o[i];
      if (addr_i == CFG_AW'(ENT_BASE + 2*i + 1)) rdata_o = ent_hi_o[i];
    end
    for (int k = 0; k < HASH_WORDS; k++) begin
      if (addr_i == CFG_AW'(HASH_BASE + k)) rdata_o = hash_o[k];
    end
  end

endmodule

// File: rtl/afilt_exact.sv
module afilt_exact
  import afilt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDXW        = 2
) (
  input  logic [47:0]     da_i,
  input  logic [31:0]     ent_lo_i [NUM_ENTRIES],
  input  logic [31:0]     ent_hi_i [NUM_ENTRIES],
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);

  logic [NUM_ENTRIES-1:0] hit_vec;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi] = ent_hi_i[gi][EN_BIT] &&
                         ({ent_hi_i[gi][15:0], ent_lo_i[gi]} == da_i);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDXW'(i);
    end
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/afilt_hash.sv
module afilt_hash
  import afilt_pkg::*;
#(
  parameter int HASH_BINS  = 64,
  parameter int HASH_WORDS = 2,
  parameter int BIN_W      = 6
) (
  input  logic [47:0]      da_i,
  input  logic [31:0]      hash_i [HASH_WORDS],
  output logic [BIN_W-1:0] bin_o,
  output logic             hit_o
);

  logic [31:0] crc_reg;
  logic [31:0] crc_fin;
  logic        fb;

  // Reflected CRC-32, one address bit per step, lowest bit first.
  always_comb begin
    crc_reg = '1;
    fb      = 1'b0;
    for (int k = 0; k < 48; k++) begin
      fb      = crc_reg[0] ^ da_i[k];
      crc_reg = crc_reg >> 1;
      if (fb) crc_reg = crc_reg ^ CRC_POLY_REFL;
    end
    crc_fin = ~crc_reg;
    // Top bits of the bit-reversed CRC are its low bits, reversed.
    for (int j = 0; j < BIN_W; j++)
      bin_o[BIN_W-1-j] = crc_fin[j];
  end

  logic [31:0] sel_word;
  assign sel_word = hash_i[bin_o[BIN_W-1:5]];
  assign hit_o    = sel_word[bin_o[4:0]];

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int HASH_BINS   = 64,
  parameter int CFG_AW      = 6,
  localparam int IDXW       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int HASH_WORDS = HASH_BINS / 32,
  localparam int BIN_W      = $clog2(HASH_BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [47:0]       lk_da,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept,
  output logic              res_perfect_hit,
  output logic [IDXW-1:0]   res_index,
  output logic              res_pass_ctrl
);

  filt_mode_t  mode_word;
  logic [31:0] ent_lo [NUM_ENTRIES];
  logic [31:0] ent_hi [NUM_ENTRIES];
  logic [31:0] hash_w [HASH_WORDS];

  afilt_regs #(
    .NUM_ENTRIES(NUM_ENTRIES), .HASH_WORDS(HASH_WORDS), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .mode_o(mode_word),
    .ent_lo_o(ent_lo), .ent_hi_o(ent_hi), .hash_o(hash_w)
  );

  logic            ex_hit;
  logic [IDXW-1:0] ex_idx;

  afilt_exact #(.NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW)) u_exact (
    .da_i(lk_da), .ent_lo_i(ent_lo), .ent_hi_i(ent_hi),
    .hit_o(ex_hit), .idx_o(ex_idx)
  );

  logic             hs_hit;
  logic [BIN_W-1:0] hs_bin;

  afilt_hash #(.HASH_BINS(HASH_BINS), .HASH_WORDS(HASH_WORDS), .BIN_W(BIN_W)) u_hash (
    .da_i(lk_da), .hash_i(hash_w), .bin_o(hs_bin), .hit_o(hs_hit)
  );

  // Verdict combine.
  logic is_group, is_bcast, class_hashed, class_ok, accept_d;
  assign is_group     = lk_da[0];
  assign is_bcast     = &lk_da;
  assign class_hashed = is_group ? mode_word.hash_mcast : mode_word.hash_ucast;
  assign class_ok     = class_hashed ? (hs_hit || (mode_word.hash_or_exact && ex_hit))
                                     : ex_hit;
  assign accept_d     = mode_word.promisc || is_bcast ||
                        (is_group && mode_word.pass_mcast) || class_ok;

  // One-deep result slot.
  logic take;
  assign lk_ready = !res_valid || res_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      res_accept      <= 1'b0;
      res_perfect_hit <= 1'b0;
      res_index       <= '0;
      res_pass_ctrl   <= 1'b0;
    end else if (take) begin
      res_valid       <= 1'b1;
      res_accept      <= accept_d;
      res_perfect_hit <= ex_hit;
      res_index       <= ex_idx;
      res_pass_ctrl   <= mode_word.promisc;
    end else if (res_ready) begin
      res_valid       <= 1'b0;
    end
  end

endmodule

// File: rtl/afilt_checker.sv
module afilt_checker #(
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic [47:0]     lk_da,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_accept,
  input logic            res_perfect_hit,
  input logic [IDXW-1:0] res_index,
  input logic            res_pass_ctrl,
  input logic            mode_promisc
);

  assert_result_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept) &&
      $stable(res_perfect_hit) && $stable(res_index) && $stable(res_pass_ctrl)));

  assert_drain_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !(lk_valid && lk_ready)) |=> !res_valid);

  assert_bcast_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && (&lk_da)) |=> res_accept);

  assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && mode_promisc) |=> (res_accept && res_pass_ctrl));

  assert_ctrl_implies_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass_ctrl) |-> res_accept);

endmodule

bind rx_addr_filter afilt_checker #(.IDXW(IDXW)) u_afilt_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_da(lk_da), .res_valid(res_valid), .res_ready(res_ready),
  .res_accept(res_accept), .res_perfect_hit(res_perfect_hit),
  .res_index(res_index), .res_pass_ctrl(res_pass_ctrl),
  .mode_promisc(mode_word.promisc)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

  localparam int NE = 4;
  localparam int BINS = 64;
  localparam int L = 6;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [47:0] lk_da = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic res_accept, res_perfect_hit, res_pass_ctrl;
  logic [1:0] res_index;

  always #4 clk = ~clk;

  rx_addr_filter #(.NUM_ENTRIES(NE), .HASH_BINS(BINS), .CFG_AW(AW)) i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_da(lk_da), .res_valid(res_valid),
    .res_ready(res_ready), .res_accept(res_accept),
    .res_perfect_hit(res_perfect_hit), .res_index(res_index),
    .res_pass_ctrl(res_pass_ctrl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side copy of the configuration, kept from the writes it issues.
  logic [4:0]  m_mode = '0;
  logic [31:0] m_lo [NE];
  logic [31:0] m_hi [NE];
  logic [31:0] m_hash [BINS/32];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Forward-form CRC on bit-reflected input: its complement equals the
  // bit-reversed reflected CRC, so the bin is simply its top L bits.
  function automatic int ref_bin(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic f = r[31] ^ da[k];
      r = r << 1;
      if (f) r = r ^ 32'h04C1_1DB7;
    end
    r = ~r;
    return int'(r >> (32 - L));
  endfunction

  // Packs {accept, exact hit, index[1:0], pass_ctrl}.
  function automatic logic [4:0] ref_verdict(input logic [47:0] da);
    logic ph = 1'b0;
    logic [1:0] ix = 2'd0;
    logic hh, grp, hashed, ok, acc;
    int b;
    for (int i = NE - 1; i >= 0; i--)
      if (m_hi[i][31] && {m_hi[i][15:0], m_lo[i]} == da) begin
        ph = 1'b1; ix = 2'(i);
      end
    b   = ref_bin(da);
    hh  = m_hash[b / 32][b % 32];
    grp = da[0];
    hashed = grp ? m_mode[2] : m_mode[3];
    ok  = hashed ? (hh | (m_mode[4] & ph)) : ph;
    acc = m_mode[0] | (&da) | (grp & m_mode[1]) | ok;
    return {acc, ph, ix, m_mode[0]};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) m_mode = d[4:0];
    else if (a >= 16 && a < 16 + 2*NE) begin
      if (a % 2 == 0) m_lo[(a-16)/2] = d;
      else            m_hi[(a-16)/2] = d & 32'h8000_FFFF;
    end else if (a >= 32 && a < 32 + BINS/32) m_hash[a-32] = d;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = AW'(a);
    #1;
    chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic set_entry(input int i, input logic [47:0] da, input bit en);
    wr(16 + 2*i, da[31:0]);
    wr(17 + 2*i, {en, 15'd0, da[47:32]});
  endtask

  task automatic lookup(input logic [47:0] da);
    @(negedge clk);
    lk_valid = 1'b1; lk_da = da;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic lookup_chk(input logic [47:0] da, input string tag);
    logic [4:0] e, a;
    lookup(da);
    e = ref_verdict(da);
    a = {res_accept, res_perfect_hit, res_index, res_pass_ctrl};
    chk(res_valid && a == e, tag, 64'({res_valid, a}), 64'({1'b1, e}));
  endtask

  localparam logic [47:0] A_UC  = 48'h5544_3322_1100;
  localparam logic [47:0] M1_MC = 48'h0A09_0807_0603;
  localparam logic [47:0] D_UC  = 48'h0C0B_0A09_0802;
  localparam logic [47:0] C_UC  = 48'h2A29_2827_2624;
  localparam logic [47:0] M2_MC = 48'h1122_3344_5501;
  localparam logic [47:0] U2_UC = 48'h99AA_BBCC_DD0E;
  localparam logic [47:0] M3_MC = 48'hF0E0_D0C0_B0A7;
  localparam logic [47:0] U3_UC = 48'h1357_9BDF_0246;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] M4_MC = 48'h0000_0000_5E01;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] addrs [10];
    logic [4:0] held;
    for (int i = 0; i < NE; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int k = 0; k < BINS/32; k++) m_hash[k] = '0;
    addrs = '{A_UC, M1_MC, D_UC, C_UC, M2_MC, U2_UC, M3_MC, U3_UC, BCAST, M4_MC};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid after reset", 64'(res_valid), 64'd0);
    chk(lk_ready == 1'b1, "R1 lk_ready after reset", 64'(lk_ready), 64'd1);
    rd_chk(0, 32'd0, "R1 mode reset");
    rd_chk(17, 32'd0, "R1 entry high reset");
    rd_chk(33, 32'd0, "R1 hash reset");

    // R2: register map and masking
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0000_001F, "R2 mode width");
    wr(19, 32'hFFFF_FFFF);
    rd_chk(19, 32'h8000_FFFF, "R2 high word mask");
    wr(18, 32'hDEAD_BEEF);
    rd_chk(18, 32'hDEAD_BEEF, "R2 low word");
    wr(8, 32'h1234_5678);
    rd_chk(8, 32'd0, "R2 unmapped address");
    wr(33, 32'hA5A5_0F0F);
    rd_chk(33, 32'hA5A5_0F0F, "R2 hash word");
    wr(0, 32'd0);

    // Entries: 0 = A, 1 = M1, 2 = D disabled, 3 = C
    set_entry(0, A_UC, 1'b1);
    set_entry(1, M1_MC, 1'b1);
    set_entry(2, D_UC, 1'b0);
    set_entry(3, C_UC, 1'b1);
    rd_chk(21, {1'b0, 15'd0, D_UC[47:32]}, "R2 disabled entry readback");

    // Hash: bins of M2 and U2 set
    begin
      int b2 = ref_bin(M2_MC);
      int b3 = ref_bin(U2_UC);
      logic [31:0] w0 = '0, w1 = '0;
      if (b2 < 32) w0[b2] = 1'b1; else w1[b2-32] = 1'b1;
      if (b3 < 32) w0[b3] = 1'b1; else w1[b3-32] = 1'b1;
      wr(32, w0); wr(33, w1);
    end

    // R3 R5 R6 R7 R8 R9 R10: sweep every mode over the address set
    for (int md = 0; md < 32; md++) begin
      wr(0, 32'(md));
      for (int j = 0; j < 10; j++)
        lookup_chk(addrs[j], $sformatf("R3 R5 R6 R7 R8 R9 R10 mode=%0d addr#%0d", md, j));
    end

    // R3: disabled entry never matches; duplicate address picks lowest index
    wr(0, 32'd0);
    lookup_chk(D_UC, "R3 disabled entry no match");
    chk(res_perfect_hit == 1'b0, "R3 disabled hit flag", 64'(res_perfect_hit), 64'd0);
    set_entry(2, C_UC, 1'b1);
    lookup_chk(C_UC, "R3 lowest index of duplicates");
    chk(res_index == 2'd2, "R3 index value", 64'(res_index), 64'd2);

    // R4: walk one bin across the table, multicast and unicast hashing
    for (int b = 0; b < BINS; b++) begin
      logic [31:0] w0 = '0, w1 = '0;
      if (b < 32) w0[b] = 1'b1; else w1[b-32] = 1'b1;
      wr(32, w0); wr(33, w1);
      wr(0, 32'h4);
      lookup_chk(M2_MC, $sformatf("R4 bin %0d mc a", b));
      lookup_chk(M3_MC ^ 48'(b << 8), $sformatf("R4 bin %0d mc b", b));
      wr(0, 32'h8);
      lookup_chk(U3_UC ^ 48'(b << 16), $sformatf("R4 bin %0d uc", b));
    end

    // R11: back-pressure holds the slot
    wr(0, 32'd0);
    res_ready = 1'b0;
    lookup(A_UC);
    held = {res_accept, res_perfect_hit, res_index, res_pass_ctrl};
    chk(res_valid && held == ref_verdict(A_UC), "R11 first verdict",
        64'({res_valid, held}), 64'({1'b1, ref_verdict(A_UC)}));
    @(negedge clk);
    lk_valid = 1'b1; lk_da = BCAST;
    #1;
    chk(lk_ready == 1'b0, "R11 lk_ready low when full", 64'(lk_ready), 64'd0);
    @(negedge clk);
    chk(res_valid && {res_accept, res_perfect_hit, res_index, res_pass_ctrl} == held,
        "R11 verdict held", 64'({res_valid, res_accept, res_perfect_hit, res_index, res_pass_ctrl}),
        64'({1'b1, held}));
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && {res_accept, res_perfect_hit, res_index, res_pass_ctrl} == ref_verdict(BCAST),
        "R11 queued lookup after drain",
        64'({res_valid, res_accept, res_perfect_hit, res_index, res_pass_ctrl}),
        64'({1'b1, ref_verdict(BCAST)}));
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 slot empties", 64'(res_valid), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule